// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block takes a 32-bit processor core from the moment it has detected a fault, trap or interrupt up to the moment it has issued the fetch of the handler's first instruction. The core presents one request. The request carries an exception kind, the pending interrupt level, the live status register, the stack pointer, and both candidate program counters (the address of the faulting instruction and the address of the next one). The sequencer latches a private copy of this context. It then runs a fixed series of steps, one at a time.

First it writes back a supervisor-mode status word together with the lowered stack pointer. For interrupts it then runs an acknowledge cycle to fetch the vector number from the interrupting peripheral. For every other kind it maps the kind to a vector number itself. Next it pushes an 8-byte frame through the write port, reads the handler address from a 256-entry table through the read port, and issues the handler fetch. Only one stack pointer exists. The frame always lands on a 4-byte boundary, and the original low two pointer bits are kept inside the frame so that a later return can restore them.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and at any time the block is idle, `busy` is low and none of `ctx_we`, `ack_valid`, `wr_valid`, `rd_valid` or `fetch_valid` is asserted.
- R2: For a request accepted while idle, `ctx_we` pulses for exactly one cycle, one cycle after acceptance. `new_sr` is the latched status with bit 13 (supervisor) set and bit 15 (trace) cleared, and all other bits unchanged for non-interrupt kinds.
- R3: For kind 7 (interrupt), `new_sr` also has bit 12 (master) cleared, and bits 10:8 (priority mask) equal to `req_level`.
- R4: Non-interrupt kinds map to fixed vectors: 0→2, 1→3, 2→4, 3→5, 4→8, 5→9, 6→14.
- R5: For kind 7 only, an acknowledge cycle runs at address `ACK_BASE + 4*level`. The vector number used afterwards is the `ack_vector` value sampled with `ack_ready`. No acknowledge cycle runs for any other kind.
- R6: `new_sp` equals the request stack pointer rounded down to a multiple of 4, minus 8.
- R7: The first frame write goes to `new_sp`. Its data carries the format field `4 + sp[1:0]` in bits 31:28, zero in bits 27:24, the vector number in bits 23:16 and the original status in bits 15:0.
- R8: The second frame write goes to `new_sp + 4` with the saved PC. The saved PC is `next_pc` for kinds 3, 5 and 7, and `fault_pc` for all other kinds.
- R9: The table read address is `{tbl_base[31:20], 20'h0} + 4*vector`.
- R10: After `rd_ready`, `fetch_valid` pulses for one cycle with `fetch_addr` equal to the `rd_data` sampled with the ready. The block is idle on the next cycle. Requests that arrive while busy are ignored.
- R11: The steps run strictly in order, one at a time. Each handshaked step holds its valid, address and data stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request, sampled while idle |
| req_kind | input | 3 | Exception kind (7 = interrupt) |
| req_level | input | 3 | Pending interrupt level |
| cur_sr | input | 16 | Live status register |
| cur_sp | input | 32 | Live stack pointer |
| fault_pc | input | 32 | Address of the faulting instruction |
| next_pc | input | 32 | Address of the next instruction |
| tbl_base | input | 32 | Vector table base (bits 19:0 ignored) |
| busy | output | 1 | Sequence in progress |
| ctx_we | output | 1 | Write strobe for new status and stack pointer |
| new_sr | output | 16 | Supervisor-mode status word |
| new_sp | output | 32 | Stack pointer after the frame push |
| ack_valid | output | 1 | Interrupt acknowledge request |
| ack_addr | output | 32 | Acknowledge address with level encoded |
| ack_ready | input | 1 | Acknowledge complete |
| ack_vector | input | 8 | Vector number returned by the peripheral |
| wr_valid | output | 1 | Frame write request |
| wr_addr | output | 32 | Frame write address |
| wr_data | output | 32 | Frame write data |
| wr_ready | input | 1 | Frame write accepted |
| rd_valid | output | 1 | Vector table read request |
| rd_addr | output | 32 | Vector table read address |
| rd_ready | input | 1 | Read data valid |
| rd_data | input | 32 | Handler address from the table |
| fetch_valid | output | 1 | Handler fetch issue pulse |
| fetch_addr | output | 32 | Handler fetch address |

## Verification
The sequence is driven with every non-interrupt kind, so that the vector map and the choice between the faulting PC and the next PC are each seen for both classes of kind. Stack pointers with each of the four low-bit patterns separate correct rounding and format recording from a design that pushes unaligned frames or drops the low bits. Interrupts at several levels, sent with status words whose trace, master and mask bits are set, check the acknowledge address encoding and the extra status changes. A table base with non-zero low bits shows that only the 1 MB-aligned part is used. Ready delays that vary per step, plus repeated requests during a busy sequence, test the hold-until-ready behaviour and the rule that requests are ignored while busy.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN           = 32;
    localparam int SR_W           = 16;
    localparam int VEC_W          = 8;
    localparam int LVL_W          = 3;
    localparam int FMT_W          = 4;
    localparam int TBL_ALIGN_BITS = 20;
    localparam int TBL_HI_W       = XLEN - TBL_ALIGN_BITS;
    localparam int FRAME_BYTES    = 8;
    localparam int WORD_BYTES     = 4;

    // status register bit positions
    localparam int SR_T      = 15;
    localparam int SR_S      = 13;
    localparam int SR_M      = 12;
    localparam int SR_IPL_LO = 8;

    localparam logic [FMT_W-1:0] FMT_BASE = 4'h4;

    typedef enum logic [2:0] {
        EX_ACCESS  = 3'd0,
        EX_ADDRESS = 3'd1,
        EX_ILLEGAL = 3'd2,
        EX_ZERODIV = 3'd3,
        EX_PRIV    = 3'd4,
        EX_TRACE   = 3'd5,
        EX_FORMAT  = 3'd6,
        EX_IRQ     = 3'd7
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STATUS,
        ST_ACK,
        ST_PUSH_HDR,
        ST_PUSH_PC,
        ST_VREAD,
        ST_FETCH
    } seq_state_e;

    typedef struct packed {
        exc_kind_e             kind;
        logic [LVL_W-1:0]      level;
        logic [SR_W-1:0]       sr;
        logic [XLEN-1:0]       sp;
        logic [XLEN-1:0]       pc;
        logic [TBL_HI_W-1:0]   tbl_hi;
    } exc_ctx_t;

    function automatic logic [XLEN-1:0] word_index(input logic [VEC_W-1:0] v);
        return XLEN'({v, 2'b00});
    endfunction

endpackage

// File: rtl/exc_vec_map.sv
module exc_vec_map
    import exc_pkg::*;
(
    input  exc_kind_e         kind,
    output logic [VEC_W-1:0]  vec,
    output logic              use_next
);

    always_comb begin
        vec      = '0;
        use_next = 1'b0;
        unique case (kind)
            EX_ACCESS:  vec = 8'd2;
            EX_ADDRESS: vec = 8'd3;
            EX_ILLEGAL: vec = 8'd4;
            EX_ZERODIV: begin vec = 8'd5;  use_next = 1'b1; end
            EX_PRIV:    vec = 8'd8;
            EX_TRACE:   begin vec = 8'd9;  use_next = 1'b1; end
            EX_FORMAT:  vec = 8'd14;
            EX_IRQ:     begin vec = 8'd0;  use_next = 1'b1; end
            default:    vec = '0;
        endcase
    end

endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_pkg::*;
(
    input  logic [SR_W-1:0]  sr_in,
    input  logic             is_irq,
    input  logic [LVL_W-1:0] level,
    output logic [SR_W-1:0]  sr_out
);

    always_comb begin
        sr_out       = sr_in;
        sr_out[SR_S] = 1'b1;
        sr_out[SR_T] = 1'b0;
        if (is_irq) begin
            sr_out[SR_M]                = 1'b0;
            sr_out[SR_IPL_LO +: LVL_W]  = level;
        end
    end

endmodule

// File: rtl/exc_frame_pack.sv
module exc_frame_pack
    import exc_pkg::*;
(
    input  logic [XLEN-1:0]  sp_in,
    input  logic [VEC_W-1:0] vec,
    input  logic [SR_W-1:0]  sr_saved,
    output logic [XLEN-1:0]  sp_after,
    output logic [XLEN-1:0]  pc_slot,
    output logic [XLEN-1:0]  hdr_word
);

    logic [XLEN-1:0]  sp_aligned;
    logic [FMT_W-1:0] fmt;

    always_comb begin
        sp_aligned = {sp_in[XLEN-1:2], 2'b00};
        sp_after   = sp_aligned - XLEN'(FRAME_BYTES);
        pc_slot    = sp_after + XLEN'(WORD_BYTES);
        fmt        = FMT_BASE | {2'b00, sp_in[1:0]};
        hdr_word   = {fmt, 4'h0, vec, sr_saved};
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter logic [31:0] ACK_BASE = 32'hFFFF_FFE0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic [2:0]  req_level,
    input  logic [15:0] cur_sr,
    input  logic [31:0] cur_sp,
    input  logic [31:0] fault_pc,
    input  logic [31:0] next_pc,
    input  logic [31:0] tbl_base,
    output logic        busy,
    output logic        ctx_we,
    output logic [15:0] new_sr,
    output logic [31:0] new_sp,
    output logic        ack_valid,
    output logic [31:0] ack_addr,
    input  logic        ack_ready,
    input  logic [7:0]  ack_vector,
    output logic        wr_valid,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    input  logic        wr_ready,
    output logic        rd_valid,
    output logic [31:0] rd_addr,
    input  logic        rd_ready,
    input  logic [31:0] rd_data,
    output logic        fetch_valid,
    output logic [31:0] fetch_addr
);

    seq_state_e        state_q, state_d;
    exc_ctx_t          ctx_q;
    logic [VEC_W-1:0]  vec_q;
    logic [XLEN-1:0]   handler_q;

    logic [VEC_W-1:0]  map_vec;
    logic              map_next;
    logic              ctx_irq;
    logic [XLEN-1:0]   pc_slot;
    logic [XLEN-1:0]   hdr_word;

    exc_vec_map u_map (
        .kind     (exc_kind_e'(req_kind)),
        .vec      (map_vec),
        .use_next (map_next)
    );

    assign ctx_irq = (ctx_q.kind == EX_IRQ);

    exc_sr_update u_sr (
        .sr_in  (ctx_q.sr),
        .is_irq (ctx_irq),
        .level  (ctx_q.level),
        .sr_out (new_sr)
    );

    exc_frame_pack u_frame (
        .sp_in    (ctx_q.sp),
        .vec      (vec_q),
        .sr_saved (ctx_q.sr),
        .sp_after (new_sp),
        .pc_slot  (pc_slot),
        .hdr_word (hdr_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_STATUS;
            ST_STATUS:   state_d = ctx_irq ? ST_ACK : ST_PUSH_HDR;
            ST_ACK:      if (ack_ready) state_d = ST_PUSH_HDR;
            ST_PUSH_HDR: if (wr_ready)  state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (wr_ready)  state_d = ST_VREAD;
            ST_VREAD:    if (rd_ready)  state_d = ST_FETCH;
            ST_FETCH:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            vec_q     <= '0;
            handler_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                ctx_q.kind   <= exc_kind_e'(req_kind);
                ctx_q.level  <= req_level;
                ctx_q.sr     <= cur_sr;
                ctx_q.sp     <= cur_sp;
                ctx_q.pc     <= map_next ? next_pc : fault_pc;
                ctx_q.tbl_hi <= tbl_base[XLEN-1:TBL_ALIGN_BITS];
                vec_q        <= map_vec;
            end
            if (state_q == ST_ACK && ack_ready) begin
                vec_q <= ack_vector;
            end
            if (state_q == ST_VREAD && rd_ready) begin
                handler_q <= rd_data;
            end
        end
    end

    // outputs decoded from state and latched context
    always_comb begin
        busy        = (state_q != ST_IDLE);
        ctx_we      = (state_q == ST_STATUS);
        ack_valid   = (state_q == ST_ACK);
        ack_addr    = ACK_BASE + XLEN'({ctx_q.level, 2'b00});
        wr_valid    = (state_q == ST_PUSH_HDR) || (state_q == ST_PUSH_PC);
        wr_addr     = (state_q == ST_PUSH_PC) ? pc_slot : new_sp;
        wr_data     = (state_q == ST_PUSH_PC) ? ctx_q.pc : hdr_word;
        rd_valid    = (state_q == ST_VREAD);
        rd_addr     = {ctx_q.tbl_hi, {TBL_ALIGN_BITS{1'b0}}} + word_index(vec_q);
        fetch_valid = (state_q == ST_FETCH);
        fetch_addr  = handler_q;
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        ctx_we,
    input logic [15:0] new_sr,
    input logic [31:0] new_sp,
    input logic        ack_valid,
    input logic [31:0] ack_addr,
    input logic        ack_ready,
    input logic        wr_valid,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic        rd_valid,
    input logic [31:0] rd_addr,
    input logic        rd_ready,
    input logic        fetch_valid
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !busy);

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(ctx_we || ack_valid || wr_valid || rd_valid || fetch_valid));

    assert_status_bits_R2: assert property (@(posedge clk) disable iff (rst)
        ctx_we |-> (new_sr[13] && !new_sr[15]));

    assert_ctx_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ctx_we |=> !ctx_we);

    assert_sp_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        ctx_we |-> (new_sp[1:0] == 2'b00));

    assert_ack_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_addr)));

    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    assert_one_step_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctx_we, ack_valid, wr_valid, rd_valid, fetch_valid}));

    assert_fetch_ends_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> !busy);

endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .ctx_we      (ctx_we),
    .new_sr      (new_sr),
    .new_sp      (new_sp),
    .ack_valid   (ack_valid),
    .ack_addr    (ack_addr),
    .ack_ready   (ack_ready),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_ready    (wr_ready),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .rd_ready    (rd_ready),
    .fetch_valid (fetch_valid)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] ACK_BASE_TB = 32'hFFFF_FFE0;

    localparam int K_CTX = 0, K_ACK = 1, K_WR = 2, K_RD = 3, K_FETCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [2:0]  req_level = '0;
    logic [15:0] cur_sr = '0;
    logic [31:0] cur_sp = '0;
    logic [31:0] fault_pc = '0;
    logic [31:0] next_pc = '0;
    logic [31:0] tbl_base = '0;
    logic        ack_ready = 1'b0;
    logic [7:0]  ack_vector = '0;
    logic        wr_ready = 1'b0;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, ctx_we, ack_valid, wr_valid, rd_valid, fetch_valid;
    logic [15:0] new_sr;
    logic [31:0] new_sp, ack_addr, wr_addr, wr_data, rd_addr, fetch_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int seed     = 5;
    int wait_cnt = 0;
    bit seen     = 1'b0;

    int          q_kind[$];
    logic [31:0] q_a[$];
    logic [31:0] q_d[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(.ACK_BASE(ACK_BASE_TB)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_level(req_level), .cur_sr(cur_sr), .cur_sp(cur_sp),
        .fault_pc(fault_pc), .next_pc(next_pc), .tbl_base(tbl_base),
        .busy(busy), .ctx_we(ctx_we), .new_sr(new_sr), .new_sp(new_sp),
        .ack_valid(ack_valid), .ack_addr(ack_addr), .ack_ready(ack_ready),
        .ack_vector(ack_vector), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int next_delay();
        seed = (seed * 13 + 7) % 101;
        return seed % 4;
    endfunction

    // requirement R4 table, computed independently of the design
    function automatic logic [7:0] kind_vec(input logic [2:0] k);
        case (k)
            3'd0: return 8'd2;
            3'd1: return 8'd3;
            3'd2: return 8'd4;
            3'd3: return 8'd5;
            3'd4: return 8'd8;
            3'd5: return 8'd9;
            3'd6: return 8'd14;
            default: return 8'd0;
        endcase
    endfunction

    function automatic bit kind_next(input logic [2:0] k);
        return (k == 3'd3) || (k == 3'd5) || (k == 3'd7);
    endfunction

    task automatic push_exp(input int k, input logic [31:0] a, input logic [31:0] d,
                            input string tag);
        q_kind.push_back(k);
        q_a.push_back(a);
        q_d.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic pop_exp();
        void'(q_kind.pop_front());
        void'(q_a.pop_front());
        void'(q_d.pop_front());
        void'(q_tag.pop_front());
    endtask

    task automatic compare_head(input int k, input logic [31:0] a, input logic [31:0] d,
                                input bit use_d);
        if (q_kind.size() == 0) begin
            check(1'b0, "R11 unexpected step", 64'(k), 64'hFF);
        end else begin
            check(q_kind[0] == k, {q_tag[0], " step kind"}, 64'(k), 64'(q_kind[0]));
            check(q_a[0] == a, {q_tag[0], " address"}, 64'(a), 64'(q_a[0]));
            if (use_d)
                check(q_d[0] == d, {q_tag[0], " data"}, 64'(d), 64'(q_d[0]));
        end
    endtask

    // cycle-by-cycle monitor and ready responder, all at the falling edge
    always @(negedge clk) begin
        int nact;
        if (!rst) begin
            ack_ready = 1'b0;
            wr_ready  = 1'b0;
            rd_ready  = 1'b0;
            nact = int'(ctx_we) + int'(ack_valid) + int'(wr_valid) + int'(rd_valid)
                 + int'(fetch_valid);
            if (nact > 1) check(1'b0, "R11 overlapping steps", 64'(nact), 64'd1);
            if (!busy && nact != 0) check(1'b0, "R1 strobe while idle", 64'(nact), 64'd0);
            if (ctx_we) begin
                compare_head(K_CTX, new_sp, {16'h0, new_sr}, 1'b1);
                if (q_kind.size() != 0) pop_exp();
            end
            if (fetch_valid) begin
                compare_head(K_FETCH, fetch_addr, 32'h0, 1'b0);
                if (q_kind.size() != 0) pop_exp();
            end
            if (ack_valid || wr_valid || rd_valid) begin
                if (!seen) begin
                    if (ack_valid) compare_head(K_ACK, ack_addr, 32'h0, 1'b0);
                    if (wr_valid)  compare_head(K_WR, wr_addr, wr_data, 1'b1);
                    if (rd_valid)  compare_head(K_RD, rd_addr, 32'h0, 1'b0);
                    seen = 1'b1;
                end
                if (wait_cnt == 0) begin
                    if (ack_valid) ack_ready = 1'b1;
                    if (wr_valid)  wr_ready  = 1'b1;
                    if (rd_valid)  rd_ready  = 1'b1;
                    if (q_kind.size() != 0) pop_exp();
                    seen     = 1'b0;
                    wait_cnt = next_delay();
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_exc(input logic [2:0] k, input logic [2:0] lvl,
                           input logic [15:0] sr, input logic [31:0] sp,
                           input logic [31:0] tb, input logic [7:0] avec,
                           input logic [31:0] handler, input int extra_req);
        logic [15:0] esr;
        logic [31:0] al, nsp, pc;
        logic [7:0]  vec;
        string       stag;
        int          t;
        bit          irq;
        irq  = (k == 3'd7);
        al   = {sp[31:2], 2'b00};
        nsp  = al - 32'd8;
        esr  = sr;
        esr[13] = 1'b1;
        esr[15] = 1'b0;
        if (irq) begin
            esr[12]   = 1'b0;
            esr[10:8] = lvl;
        end
        stag = irq ? "R3 R6 status/sp" : "R2 R6 status/sp";
        push_exp(K_CTX, nsp, {16'h0, esr}, stag);
        if (irq) begin
            push_exp(K_ACK, ACK_BASE_TB + 32'(lvl) * 32'd4, 32'h0, "R5 acknowledge");
            vec = avec;
        end else begin
            vec = kind_vec(k);
        end
        pc = kind_next(k) ? 32'h0000_4004 + 32'(k) : 32'h0000_4000 + 32'(k);
        push_exp(K_WR, nsp, {4'h4 | {2'b00, sp[1:0]}, 4'h0, vec, sr}, "R7 R4 frame header");
        push_exp(K_WR, nsp + 32'd4, pc, "R8 frame pc");
        push_exp(K_RD, {tb[31:20], 20'h0} + 32'(vec) * 32'd4, 32'h0, "R9 table read");
        push_exp(K_FETCH, handler, 32'h0, "R10 handler fetch");

        ack_vector = avec;
        rd_data    = handler;
        req_kind   = k;
        req_level  = lvl;
        cur_sr     = sr;
        cur_sp     = sp;
        fault_pc   = 32'h0000_4000 + 32'(k);
        next_pc    = 32'h0000_4004 + 32'(k);
        tbl_base   = tb;
        req_valid  = 1'b1;
        @(negedge clk);
        // R10: further requests while busy, with different content, are ignored
        for (int i = 0; i < extra_req; i++) begin
            req_kind = 3'd1;
            cur_sp   = 32'h0000_0F00;
            cur_sr   = 16'hFFFF;
            @(negedge clk);
        end
        req_valid = 1'b0;
        t = 0;
        while ((busy || q_kind.size() != 0) && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(q_kind.size() == 0 && !busy, "R10 sequence completes and idles",
              64'(q_kind.size()), 64'd0);
        repeat (2) @(negedge clk);
        check(!busy, "R10 stays idle after fetch", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !ctx_we && !ack_valid && !wr_valid && !rd_valid && !fetch_valid,
              "R1 reset state", 64'({busy, ctx_we, ack_valid, wr_valid, rd_valid, fetch_valid}),
              64'd0);

        // every non-interrupt kind, with each low stack-pointer pattern
        for (int k = 0; k < 7; k++) begin
            run_exc(3'(k), 3'd0, 16'h8700 ^ 16'(k), 32'h0001_0000 + 32'(k * 16 + (k % 4)),
                    32'h0030_0ABC, 8'h00, 32'h0000_9000 + 32'(k * 32), 0);
        end
        // interrupts at several levels with trace, master and mask bits set
        run_exc(3'd7, 3'd5, 16'h9200, 32'h0002_0003, 32'hFFF0_0000, 8'h40, 32'h0000_A000, 0);
        run_exc(3'd7, 3'd1, 16'hB700, 32'h0002_1001, 32'h0050_0004, 8'hFF, 32'h0000_B000, 0);
        run_exc(3'd7, 3'd7, 16'h1000, 32'h0002_2002, 32'h0000_0000, 8'h18, 32'h0000_C000, 3);
        // non-interrupt request with requests arriving while busy
        run_exc(3'd2, 3'd6, 16'h0700, 32'h0003_0000, 32'h0010_0000, 8'h77, 32'h0000_D000, 4);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule